// File: doc/BRIEF.md
# Ordered Write Buffer with Load Forwarding and Fences

This block sits between a core's store and load ports and a memory bus. Stores are held in an eight-deep queue and leave on a single write channel in the order the core issued them. Loads first search the queue. If the youngest queued store to the same word covers all of its bytes, the load takes that store's data and the bus is not touched. Otherwise the load is sent as a bus read, or held back when only part of the word is queued. Write-back stores to the word held by the youngest queued entry fold into that entry. Write-combining stores always take an entry of their own. Uncached accesses are never queued alongside other traffic and are never forwarded.

A command port takes four ordering commands. The store fence holds later stores until the queue is empty. The load fence holds later loads until the load engine is idle. The full fence holds both and waits for both. The drain barrier, used for I/O, locked and serializing operations, holds both until the queue is empty. Each command reports completion with a one-cycle pulse.

Memory-type codes on `st_mtype` and `ld_mtype`: 0 uncached, 1 write-combining, 2 write-back. Command codes on `fc_kind`: 0 store fence, 1 load fence, 2 full fence, 3 drain barrier. Addresses are word addresses. A store and a command accepted in the same cycle count the store as older. A load and a store accepted in the same cycle count the load as older.

Top module: `store_buffer`

## Requirements
- R1: Queued stores appear on the write channel in the order they were accepted. Address, data and byte enables stay stable while `wr_valid` is high and `wr_ready` is low.
- R2: Out of reset the queue is empty, `wr_valid` is low and `st_ready` is high. The queue holds at most 8 entries. With 8 queued, a store that cannot fold into an entry sees `st_ready` low.
- R3: A load whose word matches queued stores, where the youngest match has all byte enables set, returns that youngest store's data with `ld_resp_valid` in the cycle after acceptance, and no bus read is issued.
- R4: A load whose youngest matching queued store has some byte enables clear keeps `ld_ready` low.
- R5: A load with no queued match issues one bus read to its address. It returns the read data the cycle after `rd_resp_valid`, and `rd_addr` is held while the request waits.
- R6: A write-back store to the word of the youngest entry folds into it when that entry is write-back and is not the oldest. Its enabled bytes replace the old ones, the enables are ORed, and this is allowed even when the queue is full. Write-combining stores never fold.
- R7: An uncached store is accepted only when the queue is empty, and an uncached load only when the queue is empty. While an uncached store is queued, no store or load is accepted.
- R8: After a store fence (code 0) is accepted, no store is accepted and no completion pulse appears until the queue is empty. Loads are still accepted.
- R9: After a load fence (code 1) is accepted, no load is accepted and completion waits until every earlier load has responded. Stores are still accepted.
- R10: After a full fence (code 2) is accepted, neither loads nor stores are accepted until the queue is empty and the load engine is idle.
- R11: After a drain barrier (code 3) is accepted, neither loads nor stores are accepted. It completes once the queue is empty.
- R12: `fc_done` is high for exactly one cycle per command, and `fc_ready` is low while a command is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted when high with st_valid |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| st_mtype | input | 2 | Store memory type |
| ld_valid | input | 1 | Load request |
| ld_ready | output | 1 | Load accepted when high with ld_valid |
| ld_addr | input | AW | Load word address |
| ld_mtype | input | 2 | Load memory type |
| ld_resp_valid | output | 1 | Load data valid (one cycle) |
| ld_resp_data | output | DW | Load data |
| fc_valid | input | 1 | Ordering command request |
| fc_ready | output | 1 | No command pending |
| fc_kind | input | 2 | Command code |
| fc_done | output | 1 | Command complete pulse |
| wr_valid | output | 1 | Bus write valid |
| wr_ready | input | 1 | Bus write accepted |
| wr_addr | output | AW | Bus write word address |
| wr_data | output | DW | Bus write data |
| wr_be | output | DW/8 | Bus write byte enables |
| rd_req_valid | output | 1 | Bus read request |
| rd_req_ready | input | 1 | Bus read request accepted |
| rd_addr | output | AW | Bus read word address |
| rd_resp_valid | input | 1 | Bus read data valid |
| rd_resp_data | input | DW | Bus read data |

## Verification
A corrupted queue pointer or count shows up on the write channel as a reordered, repeated or missing write. The comparison runs when the next fence drains the queue, and a wrong count blocks or admits `st_ready` at the eighth store. A wrong age search returns an older store's data in the response cycle right after the load is accepted. A missed partial match lets a load through where `ld_ready` should have stayed low. A stuck or early fence state shows up as a completion pulse before the queue is empty, as traffic passing a fence, or as a watchdog timeout.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  typedef enum logic [1:0] {MT_UC = 2'd0, MT_WC = 2'd1, MT_WB = 2'd2} mtype_e;
  typedef enum logic [1:0] {FK_STORE = 2'd0, FK_LOAD = 2'd1, FK_FULL = 2'd2, FK_DRAIN = 2'd3} fkind_e;

  // completion condition of a pending ordering command
  function automatic logic fence_met(input logic [1:0] kind, input logic q_empty, input logic ld_idle);
    case (kind)
      FK_STORE: fence_met = q_empty;
      FK_LOAD:  fence_met = ld_idle;
      FK_FULL:  fence_met = q_empty && ld_idle;
      default:  fence_met = q_empty;
    endcase
  endfunction

  // a load may take queued data only when cacheable and fully covered
  function automatic logic fwd_take(input logic uc, input logic hit, input logic full);
    fwd_take = !uc && hit && full;
  endfunction
endpackage

// File: rtl/sbuf_fifo.sv
module sbuf_fifo #(
  parameter int DEPTH = 8,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int BW = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [AW-1:0]            push_addr,
  input  logic [DW-1:0]            push_data,
  input  logic [BW-1:0]            push_be,
  input  logic [1:0]               push_mt,
  input  logic                     merge,
  input  logic                     pop,
  output logic [$clog2(DEPTH):0]   count,
  output logic [AW-1:0]            head_addr,
  output logic [DW-1:0]            head_data,
  output logic [BW-1:0]            head_be,
  output logic [1:0]               head_mt,
  output logic [AW-1:0]            y_addr,
  output logic [1:0]               y_mt,
  input  logic [AW-1:0]            q_addr,
  output logic                     q_hit,
  output logic                     q_full,
  output logic [DW-1:0]            q_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [AW-1:0] e_addr [DEPTH];
  logic [DW-1:0] e_data [DEPTH];
  logic [BW-1:0] e_be   [DEPTH];
  logic [1:0]    e_mt   [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr, yi, idx;

  function automatic logic [DW-1:0] merge_bytes(input logic [DW-1:0] old_w,
                                                input logic [DW-1:0] new_w,
                                                input logic [BW-1:0] be);
    merge_bytes = old_w;
    for (int b = 0; b < BW; b++)
      if (be[b]) merge_bytes[8*b +: 8] = new_w[8*b +: 8];
  endfunction

  assign yi = wr_ptr - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      e_addr[wr_ptr] <= push_addr;
      e_data[wr_ptr] <= push_data;
      e_be[wr_ptr]   <= push_be;
      e_mt[wr_ptr]   <= push_mt;
    end else if (merge) begin
      e_data[yi] <= merge_bytes(e_data[yi], push_data, push_be);
      e_be[yi]   <= e_be[yi] | push_be;
    end
  end

  assign head_addr = e_addr[rd_ptr];
  assign head_data = e_data[rd_ptr];
  assign head_be   = e_be[rd_ptr];
  assign head_mt   = e_mt[rd_ptr];
  assign y_addr    = e_addr[yi];
  assign y_mt      = e_mt[yi];

  // walk oldest to youngest; the last match seen is the youngest
  always_comb begin
    q_hit  = 1'b0;
    q_full = 1'b0;
    q_data = '0;
    idx    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      idx = rd_ptr + PW'(i);
      if (CW'(i) < count && e_addr[idx] == q_addr) begin
        q_hit  = 1'b1;
        q_full = &e_be[idx];
        q_data = e_data[idx];
      end
    end
  end
endmodule

// File: rtl/sbuf_load.sv
module sbuf_load import sbuf_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [1:0]    ld_mtype,
  input  logic          blk,
  input  logic          q_empty,
  input  logic          q_hit,
  input  logic          q_full,
  input  logic [DW-1:0] q_data,
  output logic          ld_ready,
  output logic          ld_resp_valid,
  output logic [DW-1:0] ld_resp_data,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_resp_valid,
  input  logic [DW-1:0] rd_resp_data,
  output logic          ld_idle
);
  typedef enum logic [1:0] {L_IDLE, L_REQ, L_WAIT, L_RESP} lstate_e;
  lstate_e state;
  logic is_uc, partial, ld_fire;

  assign is_uc    = (ld_mtype == MT_UC);
  assign partial  = q_hit && !q_full;
  assign ld_idle  = (state == L_IDLE);
  assign ld_ready = ld_idle && !blk && (is_uc ? q_empty : !partial);
  assign ld_fire  = ld_valid && ld_ready;
  assign ld_resp_valid = (state == L_RESP);
  assign rd_req_valid  = (state == L_REQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= L_IDLE;
      rd_addr      <= '0;
      ld_resp_data <= '0;
    end else begin
      case (state)
        L_IDLE: if (ld_fire) begin
          if (fwd_take(is_uc, q_hit, q_full)) begin
            ld_resp_data <= q_data;
            state        <= L_RESP;
          end else begin
            rd_addr <= ld_addr;
            state   <= L_REQ;
          end
        end
        L_REQ:  if (rd_req_ready) state <= L_WAIT;
        L_WAIT: if (rd_resp_valid) begin
          ld_resp_data <= rd_resp_data;
          state        <= L_RESP;
        end
        default: state <= L_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sbuf_fence.sv
module sbuf_fence import sbuf_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fc_valid,
  input  logic [1:0] fc_kind,
  input  logic       q_empty,
  input  logic       ld_idle,
  output logic       fc_ready,
  output logic       fc_done,
  output logic       blk_st,
  output logic       blk_ld,
  output logic       pend,
  output logic [1:0] kind
);
  assign fc_ready = !pend;
  assign fc_done  = pend && fence_met(kind, q_empty, ld_idle);
  assign blk_st   = pend && (kind != FK_LOAD);
  assign blk_ld   = pend && (kind != FK_STORE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      kind <= '0;
    end else if (fc_valid && fc_ready) begin
      pend <= 1'b1;
      kind <= fc_kind;
    end else if (fc_done) begin
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/store_buffer.sv
module store_buffer import sbuf_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic [BW-1:0] st_be,
  input  logic [1:0]    st_mtype,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  input  logic [1:0]    ld_mtype,
  output logic          ld_resp_valid,
  output logic [DW-1:0] ld_resp_data,
  input  logic          fc_valid,
  output logic          fc_ready,
  input  logic [1:0]    fc_kind,
  output logic          fc_done,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [BW-1:0] wr_be,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_resp_valid,
  input  logic [DW-1:0] rd_resp_data
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [CW-1:0] buf_count;
  logic          buf_empty, buf_full, uc_busy, can_merge;
  logic          st_fire, st_push, st_merge, wr_pop;
  logic [AW-1:0] y_addr;
  logic [1:0]    y_mt, head_mt, fen_kind;
  logic          q_hit, q_full, blk_st, blk_ld, fen_pend, ld_idle;
  logic [DW-1:0] q_data;

  assign buf_empty = (buf_count == '0);
  assign buf_full  = (buf_count == CW'(DEPTH));
  assign uc_busy   = !buf_empty && (head_mt == MT_UC);
  assign can_merge = (st_mtype == MT_WB) && (buf_count >= CW'(2)) &&
                     (y_mt == MT_WB) && (y_addr == st_addr);
  assign st_ready  = !blk_st && !uc_busy &&
                     ((st_mtype == MT_UC) ? buf_empty : (!buf_full || can_merge));
  assign st_fire   = st_valid && st_ready;
  assign st_push   = st_fire && !can_merge;
  assign st_merge  = st_fire && can_merge;
  assign wr_valid  = !buf_empty;
  assign wr_pop    = wr_valid && wr_ready;

  sbuf_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .BW(BW)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(st_push), .push_addr(st_addr), .push_data(st_data), .push_be(st_be),
    .push_mt(st_mtype), .merge(st_merge), .pop(wr_pop), .count(buf_count),
    .head_addr(wr_addr), .head_data(wr_data), .head_be(wr_be), .head_mt(head_mt),
    .y_addr(y_addr), .y_mt(y_mt),
    .q_addr(ld_addr), .q_hit(q_hit), .q_full(q_full), .q_data(q_data)
  );

  sbuf_load #(.AW(AW), .DW(DW)) u_load (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_mtype(ld_mtype),
    .blk(blk_ld || uc_busy), .q_empty(buf_empty),
    .q_hit(q_hit), .q_full(q_full), .q_data(q_data),
    .ld_ready(ld_ready), .ld_resp_valid(ld_resp_valid), .ld_resp_data(ld_resp_data),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data), .ld_idle(ld_idle)
  );

  sbuf_fence u_fence (
    .clk(clk), .rst_n(rst_n),
    .fc_valid(fc_valid), .fc_kind(fc_kind), .q_empty(buf_empty), .ld_idle(ld_idle),
    .fc_ready(fc_ready), .fc_done(fc_done), .blk_st(blk_st), .blk_ld(blk_ld),
    .pend(fen_pend), .kind(fen_kind)
  );
endmodule

// File: rtl/store_buffer_chk.sv
module store_buffer_chk import sbuf_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int BW = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   st_valid,
  input logic                   st_ready,
  input logic [1:0]             st_mtype,
  input logic                   st_push,
  input logic                   ld_valid,
  input logic                   ld_ready,
  input logic [1:0]             ld_mtype,
  input logic                   ld_resp_valid,
  input logic                   q_hit,
  input logic                   q_full,
  input logic                   wr_valid,
  input logic                   wr_ready,
  input logic [AW-1:0]          wr_addr,
  input logic [DW-1:0]          wr_data,
  input logic [BW-1:0]          wr_be,
  input logic                   rd_req_valid,
  input logic                   rd_req_ready,
  input logic [AW-1:0]          rd_addr,
  input logic                   fc_ready,
  input logic                   fc_done,
  input logic                   fen_pend,
  input logic [1:0]             fen_kind,
  input logic [$clog2(DEPTH):0] buf_count
);
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    buf_count == DEPTH |-> !st_push); // R2
  AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_resp_valid |=> !ld_resp_valid); // R3
  AST_PARTIAL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    q_hit && !q_full && ld_mtype != MT_UC |-> !ld_ready); // R4
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_addr)); // R5
  AST_UC_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready && st_mtype == MT_UC |-> buf_count == 0); // R7
  AST_SFENCE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fen_pend && fen_kind == FK_STORE |-> !(st_valid && st_ready)); // R8
  AST_LFENCE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fen_pend && fen_kind == FK_LOAD |-> !(ld_valid && ld_ready)); // R9
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fen_pend && fen_kind == FK_FULL |-> !(st_valid && st_ready) && !(ld_valid && ld_ready)); // R10
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fc_done && fen_kind == FK_DRAIN |-> !wr_valid); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fc_done |=> !fc_done); // R12
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    fc_done |-> !fc_ready); // R12
endmodule

bind store_buffer store_buffer_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready), .st_mtype(st_mtype),
  .st_push(st_push), .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_mtype(ld_mtype),
  .ld_resp_valid(ld_resp_valid), .q_hit(q_hit), .q_full(q_full),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
  .fc_ready(fc_ready), .fc_done(fc_done), .fen_pend(fen_pend), .fen_kind(fen_kind),
  .buf_count(buf_count)
);

// File: tb/store_buffer_test.sv
module store_buffer_test;
  localparam logic [1:0] UC = 2'd0, WC = 2'd1, WB = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 0, st_ready; logic [15:0] st_addr = 0; logic [31:0] st_data = 0;
  logic [3:0] st_be = 0; logic [1:0] st_mtype = 0;
  logic ld_valid = 0, ld_ready; logic [15:0] ld_addr = 0; logic [1:0] ld_mtype = 0;
  logic ld_resp_valid; logic [31:0] ld_resp_data;
  logic fc_valid = 0, fc_ready, fc_done; logic [1:0] fc_kind = 0;
  logic wr_valid, wr_ready = 0; logic [15:0] wr_addr; logic [31:0] wr_data; logic [3:0] wr_be;
  logic rd_req_valid, rd_req_ready = 1; logic [15:0] rd_addr;
  logic rd_resp_valid = 0; logic [31:0] rd_resp_data = 0;

  always #5 clk = ~clk;

  store_buffer uut (.*);

  int n_chk = 0, n_fail = 0;
  int sink_en = 0, rd_hold = 0, rd_cnt = 0, done_cnt = 0, dbl_cnt = 0;
  logic done_wrv = 1'b0, prev_done = 1'b0;
  logic [31:0] ld_dat; int ld_rds; int seen;
  logic [51:0] exp_q[$], got_q[$];

  function automatic logic [31:0] mem_val(input logic [15:0] a);
    return {a ^ 16'h5a5a, ~a};
  endfunction
  function automatic logic [31:0] fold(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // bus write sink and fence monitor, sampled just before the rising edge
  initial forever begin
    @(negedge clk);
    wr_ready = (sink_en == 2) ? 1'b1 : (sink_en == 1) ? ($urandom % 4 != 0) : 1'b0;
    #4;
    if (wr_valid && wr_ready) got_q.push_back({wr_addr, wr_data, wr_be});
    if (fc_done) begin done_cnt++; done_wrv = wr_valid; end
    if (fc_done && prev_done) dbl_cnt++;
    prev_done = fc_done;
  end

  // bus read responder: one cycle after request acceptance
  initial begin
    logic pend = 0; logic [15:0] ra = 0;
    forever begin
      @(negedge clk);
      rd_req_ready = (rd_hold == 0);
      rd_resp_valid = pend; rd_resp_data = mem_val(ra); pend = 0;
      #4;
      if (rd_req_valid && rd_req_ready) begin pend = 1; ra = rd_addr; rd_cnt++; end
    end
  end

  task automatic st(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be, input logic [1:0] mt);
    @(negedge clk); st_valid = 1; st_addr = a; st_data = d; st_be = be; st_mtype = mt;
    forever begin #1; if (st_ready) break; @(negedge clk); end
    @(posedge clk); #1 st_valid = 0;
  endtask
  task automatic st_e(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be, input logic [1:0] mt);
    st(a, d, be, mt); exp_q.push_back({a, d, be});
  endtask
  task automatic probe_st(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be, input logic [1:0] mt, input int n);
    seen = 0;
    @(negedge clk); st_valid = 1; st_addr = a; st_data = d; st_be = be; st_mtype = mt;
    repeat (n) begin #1; if (st_ready) seen = 1; @(negedge clk); end
    st_valid = 0;
  endtask
  task automatic ld(input logic [15:0] a, input logic [1:0] mt);
    int r0 = rd_cnt;
    @(negedge clk); ld_valid = 1; ld_addr = a; ld_mtype = mt;
    forever begin #1; if (ld_ready) break; @(negedge clk); end
    @(posedge clk); #1 ld_valid = 0;
    forever begin @(negedge clk); #4; if (ld_resp_valid) break; end
    ld_dat = ld_resp_data; ld_rds = rd_cnt - r0;
  endtask
  task automatic probe_ld(input logic [15:0] a, input logic [1:0] mt, input int n);
    seen = 0;
    @(negedge clk); ld_valid = 1; ld_addr = a; ld_mtype = mt;
    repeat (n) begin #1; if (ld_ready) seen = 1; @(negedge clk); end
    ld_valid = 0;
  endtask
  task automatic fence(input logic [1:0] k);
    @(negedge clk); fc_valid = 1; fc_kind = k;
    forever begin #1; if (fc_ready) break; @(negedge clk); end
    @(posedge clk); #1 fc_valid = 0;
  endtask
  task automatic wait_done();
    int d0 = done_cnt;
    while (done_cnt == d0) @(negedge clk);
  endtask
  task automatic compare(input string req);
    chk({req, " write count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk({req, " write order"}, got_q[i], exp_q[i]);
    exp_q.delete(); got_q.delete();
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary(); $finish;
  end

  initial begin
    int d0;
    logic [15:0] last_a;
    void'($urandom(32'd7013));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R2 reset st_ready", st_ready, 1);
    chk("R2 reset wr_valid", wr_valid, 0);
    chk("R12 reset fc_ready/fc_done", {fc_ready, fc_done}, 2'b10);

    // forwarding, stall, folding, capacity, store fence
    st_e(16'h10, 32'h1111_1111, 4'hF, WC);
    st_e(16'h10, 32'h2222_2222, 4'hF, WC);
    st_e(16'h20, 32'h0000_aabb, 4'h3, WB);
    ld(16'h10, WC);
    chk("R3 youngest match data", ld_dat, 32'h2222_2222);
    chk("R3 no bus read", ld_rds, 0);
    ld(16'h30, WB);
    chk("R5 miss data", ld_dat, mem_val(16'h30));
    chk("R5 one bus read", ld_rds, 1);
    probe_ld(16'h20, WB, 6);
    chk("R4 partial match stalls", seen, 0);
    st(16'h20, 32'hccdd_0000, 4'hC, WB);
    exp_q[2] = {16'h20, 32'hccdd_aabb, 4'hF};
    ld(16'h20, WB);
    chk("R6 folded word forwarded", ld_dat, 32'hccdd_aabb);
    chk("R6 folded no bus read", ld_rds, 0);
    st_e(16'h40, 32'h0000_00ee, 4'h1, WC);
    st_e(16'h40, 32'h0000_ff00, 4'h2, WC);
    st_e(16'h50, 32'h5050_5050, 4'hF, WB);
    st_e(16'h51, 32'h5151_5151, 4'hF, WB);
    st_e(16'h52, 32'h0000_0052, 4'hF, WB);
    probe_st(16'h60, 32'h6, 4'hF, WB, 4);
    chk("R2 full blocks new store", seen, 0);
    probe_st(16'h52, 32'h7777_0000, 4'hC, WB, 1);
    chk("R6 fold accepted while full", seen, 1);
    exp_q[7] = {16'h52, 32'h7777_0052, 4'hF};
    d0 = done_cnt;
    fence(2'd0);
    probe_st(16'h70, 32'h7, 4'hF, WC, 4);
    chk("R8 store fence blocks stores", seen, 0);
    ld(16'h71, WC);
    chk("R8 loads pass store fence", ld_dat, mem_val(16'h71));
    chk("R8 no early completion", done_cnt, d0);
    sink_en = 1;
    wait_done();
    chk("R8 queue empty at completion", done_wrv, 0);
    compare("R1");
    sink_en = 0;

    // load fence
    rd_hold = 1;
    fork ld(16'h80, WC); join_none
    repeat (3) @(negedge clk);
    d0 = done_cnt;
    fence(2'd1);
    probe_st(16'h81, 32'h8181_8181, 4'hF, WC, 1);
    chk("R9 stores pass load fence", seen, 1);
    exp_q.push_back({16'h81, 32'h8181_8181, 4'hF});
    repeat (3) @(negedge clk);
    chk("R9 waits for earlier load", done_cnt, d0);
    rd_hold = 0;
    wait_done();
    repeat (2) @(negedge clk);
    chk("R9 earlier load returned", ld_dat, mem_val(16'h80));

    // full fence
    d0 = done_cnt;
    fence(2'd2);
    @(negedge clk); #1;
    chk("R12 fc_ready low while pending", fc_ready, 0);
    probe_st(16'h82, 32'h1, 4'hF, WC, 3);
    chk("R10 full fence blocks stores", seen, 0);
    probe_ld(16'h83, WC, 3);
    chk("R10 full fence blocks loads", seen, 0);
    chk("R10 no early completion", done_cnt, d0);
    sink_en = 1;
    wait_done();
    chk("R10 queue empty at completion", done_wrv, 0);
    sink_en = 0;

    // drain barrier
    st_e(16'h90, 32'h9090_9090, 4'hF, WC);
    d0 = done_cnt;
    fence(2'd3);
    probe_ld(16'h91, WC, 3);
    chk("R11 barrier blocks loads", seen, 0);
    chk("R11 no early completion", done_cnt, d0);
    sink_en = 1;
    wait_done();
    chk("R11 queue empty at completion", done_wrv, 0);
    sink_en = 0;

    // uncached
    st_e(16'ha0, 32'ha0a0_a0a0, 4'hF, WC);
    probe_st(16'ha1, 32'h1, 4'hF, UC, 3);
    chk("R7 UC store waits for empty", seen, 0);
    probe_ld(16'ha2, UC, 3);
    chk("R7 UC load waits for empty", seen, 0);
    sink_en = 2;
    forever begin @(negedge clk); #1; if (!wr_valid) break; end
    sink_en = 0;
    st_e(16'ha1, 32'ha1a1_a1a1, 4'hF, UC);
    probe_st(16'ha3, 32'h3, 4'hF, WC, 3);
    chk("R7 no store behind UC", seen, 0);
    probe_ld(16'ha1, WC, 3);
    chk("R7 no load behind UC", seen, 0);
    fence(2'd3);
    sink_en = 2;
    wait_done();
    compare("R1");

    // random mix with bus back-pressure
    sink_en = 1; last_a = 16'hffff;
    for (int i = 0; i < 80; i++) begin
      if ($urandom % 4 == 0) begin
        logic [15:0] la = 16'h200 + 16'($urandom % 256);
        ld(la, ($urandom % 2) ? WC : WB);
        chk("R5 random miss data", ld_dat, mem_val(la));
      end else begin
        logic [15:0] a = 16'h100 + 16'($urandom % 16);
        logic [3:0] be = 4'($urandom % 15 + 1);
        if (a == last_a) a = a ^ 16'h1;
        last_a = a;
        st_e(a, $urandom, be, ($urandom % 2) ? WC : WB);
      end
    end
    fence(2'd3);
    wait_done();
    compare("R1");
    chk("R12 single-cycle pulses", dbl_cnt, 0);
    summary();
    $finish;
  end
endmodule